// File: doc/BRIEF.md
# GPIO Controller with Interrupt Triggers

This block is a 32-pin general-purpose I/O peripheral. It sits behind a simple word-wide register bus that has separate read and write strobes. Each pin can be set up as an input or an output. Output levels are changed only through a write-one-to-set register and a write-one-to-clear register, so software never needs a read-modify-write to change a single pin. Every input passes through a two-flop synchronizer before anything else uses it.

Every pin can also act as an interrupt source. Three per-pin configuration bits choose the trigger:
- a sense bit picks level or edge;
- a polarity bit picks high/rising or low/falling;
- a dual-edge bit makes an edge-mode pin fire on both transitions.

Detected events are latched in a raw status register whether or not the pin is enabled. A masked view ANDs that status with the per-pin enables. A single active-high interrupt line is the OR of the masked bits. Clearing a level-mode source while the pin still sits at its active level makes the bit latch again one cycle later.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, `pin_oe` is 0, `pin_out` is 0 and `irq` is low.
- R2: Offset 0x08 is the direction register; a 1 bit makes that pin an output, so `pin_oe` follows it, and it reads back what was written.
- R3: Writing 1s at offset 0x10 sets those output latch bits and writing 1s at 0x14 clears them; 0 bits leave the latch unchanged; offset 0x00 reads the latch, which drives `pin_out`.
- R4: Offset 0x04 reads the pin levels after a two-stage synchronizer; a pin change is readable within three cycles.
- R5: With sense bit 0 (offset 0x30, edge), polarity 0 (offset 0x38) and dual-edge 0 (offset 0x34), only a rising pin transition sets its raw status bit (offset 0x24); a falling one does not.
- R6: With edge sense and polarity 1, only a falling transition sets the raw status bit.
- R7: With edge sense and dual-edge 1, both transitions set the raw status bit whatever the polarity bit.
- R8: With sense bit 1 (level), the raw status bit sets while the pin is high (polarity 0) or low (polarity 1).
- R9: Writing 1s at offset 0x2C clears those raw status bits on that clock edge; an edge-mode bit stays clear, while a level-mode bit whose pin is still active sets again on the following cycle.
- R10: Raw status latches events even when the enable bit (offset 0x20) is 0; offset 0x28 reads raw AND enable; `irq` is high exactly when any masked bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| rd_en | input | 1 | Read strobe; `rdata` updates on the same edge |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output latch |
| pin_oe | output | 32 | Output enable per pin (direction) |
| irq | output | 1 | Interrupt, high while any masked status bit is set |

## Verification
A wrong sense, polarity or dual-edge decode shows up in the raw status read about three cycles after the offending pin transition. At that point the set bit is either missing or present where it should not be. A stuck or mis-cleared status bit shows up at once on `irq` and in the masked read. A read issued on the cycle right after a level clear must return 0, and the next read must return the bit again. That pair exposes a reversed clear/set priority within two cycles.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   localparam logic [7:0] OFS_DOUT  = 8'h00;
   localparam logic [7:0] OFS_DIN   = 8'h04;
   localparam logic [7:0] OFS_DIR   = 8'h08;
   localparam logic [7:0] OFS_SET   = 8'h10;
   localparam logic [7:0] OFS_CLR   = 8'h14;
   localparam logic [7:0] OFS_EN    = 8'h20;
   localparam logic [7:0] OFS_RAW   = 8'h24;
   localparam logic [7:0] OFS_MSK   = 8'h28;
   localparam logic [7:0] OFS_ICLR  = 8'h2C;
   localparam logic [7:0] OFS_SENSE = 8'h30;
   localparam logic [7:0] OFS_DUAL  = 8'h34;
   localparam logic [7:0] OFS_POL   = 8'h38;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_irq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic cur,
   input  logic sense_lvl,
   input  logic pol_low,
   input  logic dual,
   output logic evt
);
   logic prev_q;
   logic rise, fall, edge_evt, lvl_evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= cur;
   end

   always_comb begin
      rise     = cur & ~prev_q;
      fall     = ~cur & prev_q;
      edge_evt = dual ? (rise | fall) : (pol_low ? fall : rise);
      lvl_evt  = pol_low ? ~cur : cur;
      evt      = sense_lvl ? lvl_evt : edge_evt;
   end

   // R5
   edge_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sense_lvl && evt) |-> (cur != prev_q));
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic [W-1:0] clr,
   output logic [W-1:0] raw_q
);
   // Clear takes priority on its own edge; an active level sets again next cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_q <= '0;
      else        raw_q <= (raw_q | evt) & ~clr;
   end

   // R9
   clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|clr) |=> ((raw_q & $past(clr)) == '0));

   // R10
   raw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(raw_q) & ~$past(clr)) & ~raw_q) == '0));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
   import gpio_irq_pkg::*;
#(
   parameter int NPINS       = 32,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe,
   output logic              irq
);
   generate
      if (NPINS < 1 || NPINS > DATA_W) begin : g_bad_npins
         $error("gpio_irq_ctrl: NPINS must be in 1..DATA_W");
      end
      if (ADDR_W < 6 || ADDR_W > 8) begin : g_bad_addr
         $error("gpio_irq_ctrl: ADDR_W must be in 6..8");
      end
   endgenerate

   localparam int PW = NPINS;

   logic [PW-1:0] dir_q, dout_q, en_q, sense_q, dual_q, pol_q;
   logic [PW-1:0] din_s, evt, raw_q, iclr, wd;

   assign wd = wdata[PW-1:0];

   function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
      return a == ofs[ADDR_W-1:0];
   endfunction

   function automatic logic [DATA_W-1:0] zext(input logic [PW-1:0] v);
      logic [DATA_W-1:0] r;
      r = '0;
      r[PW-1:0] = v;
      return r;
   endfunction

   // Configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= '0;
         dout_q  <= '0;
         en_q    <= '0;
         sense_q <= '0;
         dual_q  <= '0;
         pol_q   <= '0;
      end else if (wr_en) begin
         if (hit(addr, OFS_DIR))   dir_q   <= wd;
         if (hit(addr, OFS_SET))   dout_q  <= dout_q | wd;
         if (hit(addr, OFS_CLR))   dout_q  <= dout_q & ~wd;
         if (hit(addr, OFS_EN))    en_q    <= wd;
         if (hit(addr, OFS_SENSE)) sense_q <= wd;
         if (hit(addr, OFS_DUAL))  dual_q  <= wd;
         if (hit(addr, OFS_POL))   pol_q   <= wd;
      end
   end

   assign iclr = (wr_en && hit(addr, OFS_ICLR)) ? wd : '0;

   gpio_irq_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(din_s)
   );

   generate
      for (genvar p = 0; p < PW; p++) begin : g_pin
         gpio_irq_detect u_det (
            .clk(clk), .rst_n(rst_n), .cur(din_s[p]),
            .sense_lvl(sense_q[p]), .pol_low(pol_q[p]), .dual(dual_q[p]),
            .evt(evt[p])
         );
      end
   endgenerate

   gpio_irq_status #(.W(PW)) u_status (
      .clk(clk), .rst_n(rst_n), .evt(evt), .clr(iclr), .raw_q(raw_q)
   );

   // Registered read port
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (rd_en) begin
         unique case (1'b1)
            hit(addr, OFS_DOUT):  rdata <= zext(dout_q);
            hit(addr, OFS_DIN):   rdata <= zext(din_s);
            hit(addr, OFS_DIR):   rdata <= zext(dir_q);
            hit(addr, OFS_EN):    rdata <= zext(en_q);
            hit(addr, OFS_RAW):   rdata <= zext(raw_q);
            hit(addr, OFS_MSK):   rdata <= zext(raw_q & en_q);
            hit(addr, OFS_SENSE): rdata <= zext(sense_q);
            hit(addr, OFS_DUAL):  rdata <= zext(dual_q);
            hit(addr, OFS_POL):   rdata <= zext(pol_q);
            default:              rdata <= '0;
         endcase
      end
   end

   assign pin_out = dout_q;
   assign pin_oe  = dir_q;
   assign irq     = |(raw_q & en_q);

   // R3
   set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hit(addr, OFS_SET)) |=> ((pin_out & $past(wd)) == $past(wd)));

   // R3
   dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (hit(addr, OFS_SET) || hit(addr, OFS_CLR))) |=> $stable(pin_out));

   // R10
   irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0) |-> !irq);
endmodule

// File: tb/gpio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata, pin_out, pin_oe;
   logic [31:0] pin_in = '0;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t sb_q[$];
   logic  rd_d = 1'b0;

   always #10 clk = ~clk;

   gpio_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
      .pin_oe(pin_oe), .irq(irq)
   );

   // Monitor: one read result per registered read strobe
   always @(posedge clk) rd_d <= rd_en;

   always @(negedge clk) begin
      if (rd_d) begin
         item_t it;
         it = sb_q.pop_front();
         checks++;
         if (rdata !== it.exp) begin
            errors++;
            $display("FAIL %s: read got %h expected %h", it.tag, rdata, it.exp);
         end
      end
   end

   // Tasks are entered at a negedge and leave at the next negedge.
   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
      item_t it;
      it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic chk(input logic [31:0] act, input logic [31:0] e, input string tag);
      checks++;
      if (act !== e) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, act, e);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         finish_run();
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      chk(pin_oe, 32'h0, "R1 pin_oe");
      chk(pin_out, 32'h0, "R1 pin_out");
      chk({31'h0, irq}, 32'h0, "R1 irq");
      bus_rd(8'h00, 32'h0, "R1 dout");
      bus_rd(8'h08, 32'h0, "R1 dir");
      bus_rd(8'h24, 32'h0, "R1 raw");

      // R2 direction
      bus_wr(8'h08, 32'h0000_FF0F);
      chk(pin_oe, 32'h0000_FF0F, "R2 pin_oe");
      bus_rd(8'h08, 32'h0000_FF0F, "R2 dir readback");

      // R3 set / clear
      bus_wr(8'h10, 32'hA5A5_0003);
      bus_rd(8'h00, 32'hA5A5_0003, "R3 after set");
      bus_wr(8'h14, 32'h0000_0001);
      bus_rd(8'h00, 32'hA5A5_0002, "R3 after clear");
      bus_wr(8'h10, 32'h0000_0000);
      chk(pin_out, 32'hA5A5_0002, "R3 zero write keeps latch");

      // R4 synchronized input
      pin_in = 32'h1234_5678;
      idle(3);
      bus_rd(8'h04, 32'h1234_5678, "R4 din");
      pin_in = 32'h0;
      idle(4);
      bus_wr(8'h2C, 32'hFFFF_FFFF);
      bus_rd(8'h24, 32'h0, "R9 clear all");

      // R5 rising only by default
      pin_in[0] = 1'b1; idle(4);
      bus_rd(8'h24, 32'h1, "R5 rise latched");
      bus_wr(8'h2C, 32'h1);
      pin_in[0] = 1'b0; idle(4);
      bus_rd(8'h24, 32'h0, "R5 fall ignored, R9 edge stays clear");

      // R6 falling polarity on pin 1
      bus_wr(8'h38, 32'h2);
      pin_in[1] = 1'b1; idle(4);
      bus_rd(8'h24, 32'h0, "R6 rise ignored");
      pin_in[1] = 1'b0; idle(4);
      bus_rd(8'h24, 32'h2, "R6 fall latched");
      bus_wr(8'h2C, 32'h2);

      // R7 both edges on pin 2, polarity set too
      bus_wr(8'h38, 32'h6);
      bus_wr(8'h34, 32'h4);
      pin_in[2] = 1'b1; idle(4);
      bus_rd(8'h24, 32'h4, "R7 rise latched");
      bus_wr(8'h2C, 32'h4);
      pin_in[2] = 1'b0; idle(4);
      bus_rd(8'h24, 32'h4, "R7 fall latched");
      bus_wr(8'h2C, 32'h4);

      // R8 level-high on pin 3
      bus_wr(8'h30, 32'h8);
      idle(2);
      bus_rd(8'h24, 32'h0, "R8 inactive level");
      pin_in[3] = 1'b1; idle(4);
      bus_rd(8'h24, 32'h8, "R8 high level latched");
      // R9 level re-latch: first read after clear sees 0, next sees bit
      bus_wr(8'h2C, 32'h8);
      bus_rd(8'h24, 32'h0, "R9 cleared on write edge");
      bus_rd(8'h24, 32'h8, "R9 level re-latched");
      pin_in[3] = 1'b0; idle(4);
      bus_wr(8'h2C, 32'h8);
      idle(2);
      bus_rd(8'h24, 32'h0, "R9 inactive level stays clear");
      // R8 level-low
      bus_wr(8'h38, 32'hE);
      idle(2);
      bus_rd(8'h24, 32'h8, "R8 low level latched");
      bus_wr(8'h38, 32'h6);
      bus_wr(8'h2C, 32'h8);
      idle(2);
      bus_rd(8'h24, 32'h0, "R8 low level gone");

      // R10 masking
      pin_in[4] = 1'b1; idle(4);
      bus_rd(8'h24, 32'h10, "R10 raw while disabled");
      bus_rd(8'h28, 32'h0, "R10 masked while disabled");
      chk({31'h0, irq}, 32'h0, "R10 irq while disabled");
      bus_wr(8'h20, 32'h10);
      bus_rd(8'h28, 32'h10, "R10 masked after enable");
      chk({31'h0, irq}, 32'h1, "R10 irq after enable");
      bus_wr(8'h2C, 32'h10);
      chk({31'h0, irq}, 32'h0, "R10 irq after clear");

      idle(2);
      done = 1;
      if (sb_q.size() != 0) begin
         errors++;
         $display("FAIL scoreboard: got %0d left expected 0", sb_q.size());
      end
      finish_run();
   end
endmodule